// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fast-Request Steering

This block collects a parameterised set of level-sensitive interrupt lines, grouped in 32-bit banks (three banks, 96 lines, by default), and drives two active-high requests toward the processor: a normal request and a fast request. Software reaches it through a plain 32-bit register port that covers a 1 KiB window. Writes take effect on a clock edge. Reads are combinational from the addressed register.

Every bank has a pending word that follows the input levels, a fast-pending word that records fast requests until software clears them, a steering word that sends lines to the fast request, a mask word and an enable word. Three control words sit beside the banks: a base-address word and two general words for protection and the non-maskable line. The enable word and the two general words are storage only. A vector word gives the byte offset of the lowest-numbered line that is pending and not masked. It is four times the line number, so software can use it as an index into a table of handlers.

The normal request, the fast request and the vector are computed from the registered state and held in registers of their own. All three therefore change together, on the clock edge after the state that caused them.

Top module: `vic_fiq_ctrl`

## Requirements
- R1: Line n drives bit n%32 of the pending word of bank n/32. Those words sit at offsets 0x10, 0x14 and 0x18. On each clock edge a pending bit takes the current level of its line, so it is 1 while the line is high and 0 while it is low.
- R2: `cpu_irq` is 1 exactly when some bit of (pending AND NOT mask) is 1 in any bank, as that state stood one clock edge earlier. A mask bit of 1 blocks its line.
- R3: `cpu_fiq` is 1 exactly when some bit of (steer AND pending AND NOT mask) is 1, with the same one-edge delay as R2. A steer bit of 1 sends its line to the fast request.
- R4: The vector word at offset 0x00 reads (lowest line index with pending AND NOT mask set) × 4, with the same delay as R2. It reads 0 when no line is active, so line 0 and "none" read alike.
- R5: A write to a pending word (offsets 0x10 to 0x18) has no effect. The word keeps following its input lines.
- R6: A fast-pending bit (offsets 0x20, 0x24, 0x28) becomes 1 on any edge at which its line is pending, steered and not masked, and stays 1 afterwards. A write clears every bit written as 1 and keeps the others. If a clear and a new fast request fall on the same edge, the bit is set.
- R7: A write to the base-address word at 0x04 stores the written value with bits 1:0 forced to 0.
- R8: The protect word (0x08), the non-maskable word (0x0C), the steer words (0x30 to 0x38), the enable words (0x40 to 0x48) and the mask words (0x50 to 0x58) read back exactly the last value written to them.
- R9: The enable words have no effect on `cpu_irq`, `cpu_fiq` or the vector.
- R10: Reset clears every register, including the vector and both requests, to 0.
- R11: A read of an unmapped offset, or of an offset that is not a multiple of four, returns 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src | input | 96 | Level-sensitive interrupt lines, bit n is line n |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 10 | Byte offset within the 1 KiB register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cpu_irq | output | 1 | Normal interrupt request |
| cpu_fiq | output | 1 | Fast interrupt request |

## Verification
The priority search is driven with these cases:
- one active line high in the last bank, which checks the bank-times-32 term;
- lines active in two banks at once, which checks that the lowest bank wins and not the first bit found;
- only line 0 active, which checks that the request is high while the vector still reads 0;
- the lowest active line masked, which checks that the search moves on to the next line.

Lines steered and not steered, each masked and unmasked, show that the fast request depends on the steer word and the normal request does not. A long stretch of random line levels, mask words and steer words checks that all three outputs keep the one-edge latency together, as the requirements state.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int DATA_W   = 32;
   // register groups, selected by address bits [ADDR_W-1:4]
   localparam int G_CTRL   = 0;  // slot 0 vector, 1 base, 2 protect, 3 nmi
   localparam int G_PEND   = 1;
   localparam int G_FPEND  = 2;
   localparam int G_STEER  = 3;
   localparam int G_EN     = 4;
   localparam int G_MASK   = 5;
   localparam int SLOT_VEC  = 0;
   localparam int SLOT_BASE = 1;
   localparam int SLOT_PROT = 2;
   localparam int SLOT_NMI  = 3;
endpackage

// File: rtl/vic_bank.sv
module vic_bank #(
   parameter int BW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [BW-1:0] src,
   input  logic          wr_fp,
   input  logic          wr_steer,
   input  logic          wr_en,
   input  logic          wr_mask,
   input  logic [BW-1:0] wdata,
   output logic [BW-1:0] pend,
   output logic [BW-1:0] fpend,
   output logic [BW-1:0] steer,
   output logic [BW-1:0] en,
   output logic [BW-1:0] mask
);
   logic [BW-1:0] fp_hit;
   logic [BW-1:0] fp_clr;

   assign fp_hit = steer & pend & ~mask;
   assign fp_clr = wr_fp ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend  <= '0;
         fpend <= '0;
         steer <= '0;
         en    <= '0;
         mask  <= '0;
      end else begin
         pend  <= src;
         fpend <= (fpend & ~fp_clr) | fp_hit;
         if (wr_steer) steer <= wdata;
         if (wr_en)    en    <= wdata;
         if (wr_mask)  mask  <= wdata;
      end
   end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
   parameter int NBANK = 3,
   parameter int BW    = 32,
   localparam int NSRC  = NBANK * BW,
   localparam int VEC_W = $clog2(NSRC) + 2,
   localparam int POS_W = (BW > 1) ? $clog2(BW) : 1
) (
   input  logic [NSRC-1:0]  pend,
   input  logic [NSRC-1:0]  mask,
   input  logic [NSRC-1:0]  steer,
   output logic             any_irq,
   output logic             any_fiq,
   output logic [VEC_W-1:0] vec
);
   logic [NSRC-1:0]  act;
   logic [NBANK-1:0] bank_any;
   logic [POS_W-1:0] bank_pos [NBANK];

   assign act     = pend & ~mask;
   assign any_irq = |act;
   assign any_fiq = |(act & steer);

   for (genvar b = 0; b < NBANK; b++) begin : g_find
      logic [BW-1:0] slice;
      assign slice       = act[b*BW +: BW];
      assign bank_any[b] = |slice;
      always_comb begin
         bank_pos[b] = '0;
         for (int i = BW - 1; i >= 0; i--) begin
            if (slice[i]) bank_pos[b] = POS_W'(i);
         end
      end
   end

   always_comb begin
      vec = '0;
      for (int b = NBANK - 1; b >= 0; b--) begin
         if (bank_any[b]) vec = VEC_W'((b * BW + int'(bank_pos[b])) * 4);
      end
   end
endmodule

// File: rtl/vic_fiq_ctrl.sv
module vic_fiq_ctrl
   import vic_pkg::*;
#(
   parameter int NBANK  = 3,
   parameter int BW     = 32,
   parameter int ADDR_W = 10,
   localparam int NSRC  = NBANK * BW,
   localparam int VEC_W = $clog2(NSRC) + 2,
   localparam int GRP_W = ADDR_W - 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   irq_src,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              cpu_irq,
   output logic              cpu_fiq
);
   if (NBANK < 1 || NBANK > 4) begin : g_bad_nbank
      $error("NBANK must lie in 1..4");
   end
   if (BW < 1 || BW > DATA_W) begin : g_bad_bw
      $error("BW must lie in 1..DATA_W");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too small for the register groups");
   end

   logic [GRP_W-1:0]  grp;
   logic [1:0]        slot;
   logic              aligned;
   logic [NSRC-1:0]   pend_all, fpend_all, steer_all, en_all, mask_all;
   logic [DATA_W-1:0] base_q, prot_q, nmi_q;
   logic [VEC_W-1:0]  vec_d, vec_q;
   logic              irq_d, fiq_d;

   assign grp     = bus_addr[ADDR_W-1:4];
   assign slot    = bus_addr[3:2];
   assign aligned = (bus_addr[1:0] == 2'b00);

   function automatic logic hit(input logic [GRP_W-1:0] g, input logic [1:0] s,
                                input int want_g, input int want_s);
      return (g == GRP_W'(want_g)) && (s == 2'(want_s));
   endfunction

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      vic_bank #(.BW(BW)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .src      (irq_src[b*BW +: BW]),
         .wr_fp    (bus_we && aligned && hit(grp, slot, G_FPEND, b)),
         .wr_steer (bus_we && aligned && hit(grp, slot, G_STEER, b)),
         .wr_en    (bus_we && aligned && hit(grp, slot, G_EN, b)),
         .wr_mask  (bus_we && aligned && hit(grp, slot, G_MASK, b)),
         .wdata    (bus_wdata[BW-1:0]),
         .pend     (pend_all[b*BW +: BW]),
         .fpend    (fpend_all[b*BW +: BW]),
         .steer    (steer_all[b*BW +: BW]),
         .en       (en_all[b*BW +: BW]),
         .mask     (mask_all[b*BW +: BW])
      );
   end

   // control words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         prot_q <= '0;
         nmi_q  <= '0;
      end else if (bus_we && aligned) begin
         if (hit(grp, slot, G_CTRL, SLOT_BASE)) base_q <= {bus_wdata[DATA_W-1:2], 2'b00};
         if (hit(grp, slot, G_CTRL, SLOT_PROT)) prot_q <= bus_wdata;
         if (hit(grp, slot, G_CTRL, SLOT_NMI))  nmi_q  <= bus_wdata;
      end
   end

   vic_prio #(.NBANK(NBANK), .BW(BW)) u_prio (
      .pend    (pend_all),
      .mask    (mask_all),
      .steer   (steer_all),
      .any_irq (irq_d),
      .any_fiq (fiq_d),
      .vec     (vec_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_irq <= 1'b0;
         cpu_fiq <= 1'b0;
         vec_q   <= '0;
      end else begin
         cpu_irq <= irq_d;
         cpu_fiq <= fiq_d;
         vec_q   <= vec_d;
      end
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         if (grp == GRP_W'(G_CTRL)) begin
            case (slot)
               2'(SLOT_VEC):  bus_rdata = DATA_W'(vec_q);
               2'(SLOT_BASE): bus_rdata = base_q;
               2'(SLOT_PROT): bus_rdata = prot_q;
               default:       bus_rdata = nmi_q;
            endcase
         end else begin
            for (int b = 0; b < NBANK; b++) begin
               if (slot == 2'(b)) begin
                  if (grp == GRP_W'(G_PEND))  bus_rdata = DATA_W'(pend_all[b*BW +: BW]);
                  if (grp == GRP_W'(G_FPEND)) bus_rdata = DATA_W'(fpend_all[b*BW +: BW]);
                  if (grp == GRP_W'(G_STEER)) bus_rdata = DATA_W'(steer_all[b*BW +: BW]);
                  if (grp == GRP_W'(G_EN))    bus_rdata = DATA_W'(en_all[b*BW +: BW]);
                  if (grp == GRP_W'(G_MASK))  bus_rdata = DATA_W'(mask_all[b*BW +: BW]);
               end
            end
         end
      end
   end
endmodule

// File: rtl/vic_fiq_ctrl_chk.sv
module vic_fiq_ctrl_chk #(
   parameter int NBANK  = 3,
   parameter int BW     = 32,
   parameter int ADDR_W = 10,
   parameter int VEC_W  = 9
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NBANK*BW-1:0]     irq_src,
   input logic [NBANK*BW-1:0]     pend_all,
   input logic [NBANK*BW-1:0]     fpend_all,
   input logic [NBANK*BW-1:0]     mask_all,
   input logic [NBANK*BW-1:0]     steer_all,
   input logic                    bus_we,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [31:0]             base_q,
   input logic [VEC_W-1:0]        vec_q,
   input logic                    cpu_irq,
   input logic                    cpu_fiq
);
   logic armed;
   logic fp_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assign fp_write = bus_we && (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(2));

   // R1
   pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> pend_all == $past(irq_src));

   // R2
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> cpu_irq == (|($past(pend_all) & ~$past(mask_all))));

   // R3
   fiq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> cpu_fiq == (|($past(pend_all) & $past(steer_all) & ~$past(mask_all))));

   // R3
   fiq_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_fiq |-> cpu_irq);

   // R4
   idle_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_irq |-> vec_q == '0);

   // R6
   fpend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(fp_write)) |-> (($past(fpend_all) & ~fpend_all) == '0));

   // R7
   base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_q[1:0] == 2'b00);
endmodule

bind vic_fiq_ctrl vic_fiq_ctrl_chk #(
   .NBANK(NBANK), .BW(BW), .ADDR_W(ADDR_W), .VEC_W(VEC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_src   (irq_src),
   .pend_all  (pend_all),
   .fpend_all (fpend_all),
   .mask_all  (mask_all),
   .steer_all (steer_all),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .base_q    (base_q),
   .vec_q     (vec_q),
   .cpu_irq   (cpu_irq),
   .cpu_fiq   (cpu_fiq)
);

// File: tb/vic_fiq_ctrl_tb.sv
`timescale 1ns/1ps
module vic_fiq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [95:0] irq_src = '0;
   logic        bus_we = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cpu_irq, cpu_fiq;

   always #2.5 clk = ~clk;

   vic_fiq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq)
   );

   // reference model state
   logic [31:0] m_pend [3];
   logic [31:0] m_fp   [3];
   logic [31:0] m_sel  [3];
   logic [31:0] m_en   [3];
   logic [31:0] m_mask [3];
   logic [31:0] m_base, m_prot, m_nmi, m_vec;
   logic        m_irq, m_fiq;

   int    vectors = 0;
   int    miscompares = 0;
   int    cycles = 0;
   string cur_req = "R10";

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < 3; b++) begin
            m_pend[b] = 0; m_fp[b] = 0; m_sel[b] = 0; m_en[b] = 0; m_mask[b] = 0;
         end
         m_base = 0; m_prot = 0; m_nmi = 0; m_vec = 0; m_irq = 0; m_fiq = 0;
      end else begin
         logic        any_i, any_f, found;
         int          first;
         logic [31:0] clr, a;
         any_i = 0; any_f = 0; found = 0; first = 0;
         for (int n = 0; n < 96; n++) begin
            if (m_pend[n/32][n%32] && !m_mask[n/32][n%32]) begin
               any_i = 1;
               if (m_sel[n/32][n%32]) any_f = 1;
               if (!found) begin found = 1; first = n; end
            end
         end
         m_irq = any_i; m_fiq = any_f; m_vec = found ? first * 4 : 0;
         for (int b = 0; b < 3; b++) begin
            clr = 0;
            if (bus_we && bus_addr == 10'h20 + 10'(4*b)) clr = bus_wdata;
            a = m_sel[b] & m_pend[b] & ~m_mask[b];
            m_fp[b] = (m_fp[b] & ~clr) | a;
         end
         if (bus_we) begin
            case (bus_addr)
               10'h04: m_base = bus_wdata & 32'hFFFF_FFFC;
               10'h08: m_prot = bus_wdata;
               10'h0C: m_nmi  = bus_wdata;
               10'h30: m_sel[0] = bus_wdata;
               10'h34: m_sel[1] = bus_wdata;
               10'h38: m_sel[2] = bus_wdata;
               10'h40: m_en[0] = bus_wdata;
               10'h44: m_en[1] = bus_wdata;
               10'h48: m_en[2] = bus_wdata;
               10'h50: m_mask[0] = bus_wdata;
               10'h54: m_mask[1] = bus_wdata;
               10'h58: m_mask[2] = bus_wdata;
               default: ;
            endcase
         end
         for (int b = 0; b < 3; b++) m_pend[b] = irq_src[b*32 +: 32];
      end
   end

   function automatic logic [31:0] exp_rd(input logic [9:0] a);
      case (a)
         10'h00: return m_vec;
         10'h04: return m_base;
         10'h08: return m_prot;
         10'h0C: return m_nmi;
         10'h10: return m_pend[0];
         10'h14: return m_pend[1];
         10'h18: return m_pend[2];
         10'h20: return m_fp[0];
         10'h24: return m_fp[1];
         10'h28: return m_fp[2];
         10'h30: return m_sel[0];
         10'h34: return m_sel[1];
         10'h38: return m_sel[2];
         10'h40: return m_en[0];
         10'h44: return m_en[1];
         10'h48: return m_en[2];
         10'h50: return m_mask[0];
         10'h54: return m_mask[1];
         10'h58: return m_mask[2];
         default: return 32'h0;
      endcase
   endfunction

   // compare on every falling edge, before new stimulus is driven
   always @(negedge clk) begin
      if (cycles > 0) begin
         vectors++;
         if (cpu_irq !== m_irq) begin
            miscompares++;
            $display("FAIL %s: cpu_irq got %0b exp %0b", cur_req, cpu_irq, m_irq);
         end
         if (cpu_fiq !== m_fiq) begin
            miscompares++;
            $display("FAIL %s: cpu_fiq got %0b exp %0b", cur_req, cpu_fiq, m_fiq);
         end
         if (bus_rdata !== exp_rd(bus_addr)) begin
            miscompares++;
            $display("FAIL %s: rdata @%h got %h exp %h", cur_req, bus_addr, bus_rdata,
                     exp_rd(bus_addr));
         end
      end
      cycles++;
      if (cycles > 100000) begin
         miscompares++;
         $display("FAIL watchdog: got %0d cycles exp below 100000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic cyc(input logic [95:0] s, input logic we, input logic [9:0] a,
                      input logic [31:0] d);
      @(negedge clk);
      #1;
      irq_src = s; bus_we = we; bus_addr = a; bus_wdata = d;
   endtask

   task automatic rd(input logic [9:0] a);
      cyc(irq_src, 1'b0, a, 32'h0);
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      cyc(irq_src, 1'b1, a, d);
   endtask

   task automatic src(input logic [95:0] s, input logic [9:0] a);
      cyc(s, 1'b0, a, 32'h0);
      rd(a);
      rd(a);
   endtask

   initial begin
      // R10: reset state, with inputs active during reset
      cur_req = "R10";
      cyc(96'hFFFF, 1'b0, 10'h10, 0);
      rd(10'h00); rd(10'h14);
      cyc('0, 1'b0, 10'h00, 0);
      rd(10'h00);
      @(negedge clk); #1 rst_n = 1'b1;
      for (int a = 0; a < 'h60; a += 4) rd(10'(a));

      // R8: plain storage
      cur_req = "R8";
      wr(10'h08, 32'hA5A5_5A5A); rd(10'h08);
      wr(10'h0C, 32'h1234_5678); rd(10'h0C);
      wr(10'h30, 32'h0000_00F0); rd(10'h30);
      wr(10'h38, 32'h8000_0000); rd(10'h38);
      wr(10'h40, 32'hDEAD_BEEF); rd(10'h40);
      wr(10'h54, 32'h0000_FFFF); rd(10'h54);
      wr(10'h54, 32'h0); rd(10'h54);

      // R7: base alignment
      cur_req = "R7";
      wr(10'h04, 32'hFFFF_FFFF); rd(10'h04);
      wr(10'h04, 32'h0000_1237); rd(10'h04);

      // R1: pending follows levels
      cur_req = "R1";
      src(96'h1 << 5, 10'h10);
      src(96'h1 << 40, 10'h14);
      src(96'h1 << 95, 10'h18);
      src('0, 10'h18);

      // R2 and R4: request and vector
      cur_req = "R4";
      src(96'h1 << 70, 10'h00);
      src((96'h1 << 95) | (96'h1 << 40), 10'h00);
      cur_req = "R2";
      src(96'h1, 10'h00);
      wr(10'h50, 32'h1); rd(10'h00); rd(10'h00);
      cur_req = "R4";
      src(96'h1 | (96'h1 << 3), 10'h00);
      wr(10'h50, 32'h0); rd(10'h00); rd(10'h00);
      src('0, 10'h00);

      // R3: fast request steering (steer bank0 = 0xF0, bank2 bit 31)
      cur_req = "R3";
      src(96'h1 << 4, 10'h00);
      src(96'h1 << 2, 10'h00);
      src(96'h1 << 95, 10'h00);
      wr(10'h58, 32'h8000_0000); rd(10'h00); rd(10'h00);
      wr(10'h58, 32'h0); rd(10'h00);

      // R6: fast-pending sticky and write-one-to-clear
      cur_req = "R6";
      src(96'h30, 10'h20);
      src('0, 10'h20);
      wr(10'h20, 32'h10); rd(10'h20);
      wr(10'h28, 32'hFFFF_FFFF); rd(10'h28);
      cyc(96'h20, 1'b1, 10'h20, 32'h20); rd(10'h20); rd(10'h20);
      cyc('0, 1'b1, 10'h20, 32'hFFFF_FFFF); rd(10'h20); rd(10'h20);

      // R5: writes to pending discarded
      cur_req = "R5";
      cyc(96'h1 << 33, 1'b0, 10'h14, 0);
      wr(10'h14, 32'h0); rd(10'h14);
      cyc('0, 1'b1, 10'h10, 32'hFFFF_FFFF); rd(10'h10); rd(10'h00);

      // R9: enable has no effect
      cur_req = "R9";
      wr(10'h44, 32'hFFFF_FFFF); rd(10'h00); rd(10'h00);
      src(96'h1 << 33, 10'h00);
      wr(10'h44, 32'h0); rd(10'h00); rd(10'h00);
      src('0, 10'h44);

      // R11: unmapped and unaligned offsets
      cur_req = "R11";
      wr(10'h60, 32'hFFFF_FFFF); rd(10'h60);
      wr(10'h2C, 32'hFFFF_FFFF); rd(10'h2C);
      wr(10'h32, 32'h1111_1111); rd(10'h30); rd(10'h32);
      wr(10'h09, 32'h2222_2222); rd(10'h08);
      rd(10'h1C); rd(10'h3FC); rd(10'h5C);

      // R2: random stretch of levels, masks and steering
      cur_req = "R2";
      for (int i = 0; i < 400; i++) begin
         logic [95:0] s;
         logic [9:0]  a;
         s = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
         if (i % 7 == 0) s = '0;
         a = 10'(16 * ($urandom % 6) + 4 * ($urandom % 3));
         cyc(s, (i % 3 == 0), a, $urandom);
      end
      rd(10'h00);
      rd(10'h00);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule